// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers level interrupt lines from up to 32 on-chip peripherals into one memory-mapped register set. Each line that goes high leaves a trace in a pending register and, if its mask bit is set, in a request register. The processor is not signalled by a wire. Each masked-in rising edge produces one outbound 32-bit bus write instead, and a programmable interrupt address register supplies both the target of that write and its payload.

Software reaches the block through a simple slave port. Every access takes one cycle and writes carry byte-lane strobes. Outbound writes go through a master port that uses request and acknowledge. Rising edges that arrive together, or that arrive while a write is still outstanding, are queued and issued one at a time. When edges arrive together, the lowest source number is queued first. A bus-error flag in the control register holds back new deliveries. An error-log register and an arbitration-mask register give plain storage, and a version register always reads zero.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, the request, mask, pending and control registers read zero. The interrupt address register reads the value of IAR_RESET. msg_req_o and mask_err_o are low.
- R2: For every cycle that src_i[n] is high, pending bit n (offset 0x08) is set at the next clock edge. Pending bits stay set after the line falls.
- R3: A read of pending returns the register's current value and clears it in the same access. Any write to pending also clears it, whatever the data or strobes. A line that is still high sets its bit again.
- R4: Request bit n (offset 0x00) is set while src_i[n] and mask bit n (offset 0x04) are both high. It stays set until reset. Software writes to offset 0x00 have no effect.
- R5: A rising edge on src_i[n] while mask bit n is set produces exactly one outbound write, even if the line stays high. The write's address is the interrupt address register (offset 0x10) with bits 4:0 cleared. Its data is those 5 bits, zero-extended.
- R6: While control bit 8 (offset 0x0C) is set, rising edges produce no outbound write. A control read returns bit 8, and all other bits read zero.
- R7: The valid mask bits are 5, 7, 8, 9, 13, 14, 16 to 21 and 26, which is the value 0x043F63A0. A mask write whose enabled lanes set any other bit raises mask_err_o for the one cycle after the write. A write that sets only valid bits leaves mask_err_o low.
- R8: Outbound writes are issued one at a time. msg_req_o, msg_addr_o and msg_data_o hold steady until msg_ack_i is high at a clock edge, and that edge completes the write. Edges that arrive together each give one write.
- R9: The error log (0x0C004) and the arbitration mask (0x0C010) are read/write storage. reg_be_i[k] enables bits 8k+7:8k. The version register (0x0C008) reads zero after any write.
- R10: Read data appears on reg_rdata_o in the cycle after the read request and is zero in other cycles. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt lines, one per source |
| reg_req_i | input | 1 | Slave access request, one cycle per access |
| reg_we_i | input | 1 | High for write, low for read |
| reg_addr_i | input | 20 | Byte offset of the register |
| reg_be_i | input | 4 | Byte-lane write strobes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| mask_err_o | output | 1 | Pulse after a mask write that sets an invalid bit |
| msg_req_o | output | 1 | Outbound write pending |
| msg_addr_o | output | 32 | Outbound write address, 32-byte aligned |
| msg_data_o | output | 32 | Outbound write data |
| msg_ack_i | input | 1 | Outbound write accepted |

## Verification
The edge-tracking state and the queue decide how many outbound writes appear, so a fault in either one shows up at the ports. A stale edge register shows up as a missing or repeated write within a few cycles of a line rising. A lost or duplicated queue entry shows up as a wrong write count once the queue drains. A pending or request register that is set, cleared or masked wrongly shows up on the next read of offset 0x08 or 0x00, one cycle after that read. A wrong payload snapshot shows up on the very first write, because its address and data would not match the interrupt address register.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned NSRC   = 32;
  localparam int unsigned DW     = 32;
  localparam int unsigned REG_AW = 20;
  localparam int unsigned BEW    = DW / 8;

  localparam logic [REG_AW-1:0] OFF_REQ  = 20'h00000;
  localparam logic [REG_AW-1:0] OFF_MASK = 20'h00004;
  localparam logic [REG_AW-1:0] OFF_PEND = 20'h00008;
  localparam logic [REG_AW-1:0] OFF_CTL  = 20'h0000C;
  localparam logic [REG_AW-1:0] OFF_IAR  = 20'h00010;
  localparam logic [REG_AW-1:0] OFF_ELOG = 20'h0C004;
  localparam logic [REG_AW-1:0] OFF_VER  = 20'h0C008;
  localparam logic [REG_AW-1:0] OFF_ARB  = 20'h0C010;

  localparam logic [DW-1:0] VALID_MASK = 32'h043F_63A0;
  localparam int unsigned   BUSERR_BIT = 8;
  localparam int unsigned   OFS_BITS   = 5;

  function automatic logic [DW-1:0] lanes(input logic [BEW-1:0] be);
    logic [DW-1:0] m;
    for (int k = 0; k < BEW; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/msi_edge_det.sv
module msi_edge_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/msi_first_set.sv
module msi_first_set #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] onehot_o
);
  // lowest set bit
  assign onehot_o = vec_i & (~vec_i + N'(1));
endmodule

// File: rtl/msi_fifo.sv
module msi_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter logic [31:0] IAR_RESET  = 32'hFFFE_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BEW-1:0]    reg_be_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              mask_err_o,
  output logic              msg_req_o,
  output logic [DW-1:0]     msg_addr_o,
  output logic [DW-1:0]     msg_data_o,
  input  logic              msg_ack_i
);
  logic [NSRC-1:0] req_q, mask_q, pend_q, todo_q;
  logic            buserr_q;
  logic [DW-1:0]   iar_q, elog_q, arb_q, rdata_q;
  logic            mask_err_q;

  logic [NSRC-1:0] rise, hit, first, todo_d;
  logic [DW-1:0]   wmask, rd_mux, head;
  logic            wr, rd, push, full, empty;

  assign wr    = reg_req_i & reg_we_i;
  assign rd    = reg_req_i & ~reg_we_i;
  assign wmask = lanes(reg_be_i);

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old);
    return (old & ~wmask) | (reg_wdata_i & wmask);
  endfunction

  msi_edge_det #(.N(NSRC)) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (src_i),
    .rise_o  (rise)
  );

  assign hit = rise & mask_q & {NSRC{~buserr_q}};

  msi_first_set #(.N(NSRC)) i_first (
    .vec_i    (todo_q),
    .onehot_o (first)
  );

  assign push   = (|todo_q) & ~full;
  assign todo_d = (todo_q & ~(push ? first : '0)) | hit;

  msi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (iar_q),
    .pop_i   (msg_req_o & msg_ack_i),
    .rdata_o (head),
    .full_o  (full),
    .empty_o (empty)
  );

  assign msg_req_o  = ~empty;
  assign msg_addr_o = {head[DW-1:OFS_BITS], {OFS_BITS{1'b0}}};
  assign msg_data_o = {{(DW-OFS_BITS){1'b0}}, head[OFS_BITS-1:0]};

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      OFF_REQ:  rd_mux = req_q;
      OFF_MASK: rd_mux = mask_q;
      OFF_PEND: rd_mux = pend_q;
      OFF_CTL:  rd_mux[BUSERR_BIT] = buserr_q;
      OFF_IAR:  rd_mux = iar_q;
      OFF_ELOG: rd_mux = elog_q;
      OFF_ARB:  rd_mux = arb_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      todo_q     <= '0;
      buserr_q   <= 1'b0;
      iar_q      <= IAR_RESET;
      elog_q     <= '0;
      arb_q      <= '0;
      rdata_q    <= '0;
      mask_err_q <= 1'b0;
    end else begin
      todo_q  <= todo_d;
      req_q   <= req_q | (src_i & mask_q);
      // any access to pending clears it; live levels set it again
      pend_q  <= ((reg_req_i && reg_addr_i == OFF_PEND) ? '0 : pend_q) | src_i;
      rdata_q <= rd ? rd_mux : '0;
      mask_err_q <= wr && (reg_addr_i == OFF_MASK) &&
                    (|(reg_wdata_i & wmask & ~VALID_MASK));
      if (wr) begin
        unique case (reg_addr_i)
          OFF_MASK: mask_q <= merge(mask_q);
          OFF_CTL:  if (wmask[BUSERR_BIT]) buserr_q <= reg_wdata_i[BUSERR_BIT];
          OFF_IAR:  iar_q  <= merge(iar_q);
          OFF_ELOG: elog_q <= merge(elog_q);
          OFF_ARB:  arb_q  <= merge(arb_q);
          default:  ;
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign mask_err_o  = mask_err_q;
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
module msi_irq_ctrl_chk
  import msi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              mask_err_o,
  input logic              msg_req_o,
  input logic [DW-1:0]     msg_addr_o,
  input logic [DW-1:0]     msg_data_o,
  input logic              msg_ack_i
);
  assert_hold_until_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && !msg_ack_i |=> msg_req_o && $stable(msg_addr_o) && $stable(msg_data_o));

  assert_payload_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o |-> (msg_addr_o[OFS_BITS-1:0] == '0) && (msg_data_o[DW-1:OFS_BITS] == '0));

  assert_ctl_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == OFF_CTL |=> (reg_rdata_o & ~(32'h1 << BUSERR_BIT)) == '0);

  assert_ver_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == OFF_VER |=> reg_rdata_o == '0);

  assert_err_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_err_o |-> $past(reg_req_i && reg_we_i && reg_addr_i == OFF_MASK));

  assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_i && !reg_we_i) |=> reg_rdata_o == '0);
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk i_chk (.*);

// File: tb/test_msi_irq_ctrl.sv
module test_msi_irq_ctrl;
  localparam logic [31:0] IAR_RST = 32'hFFFE_0003;
  localparam logic [31:0] VALID   = 32'h043F_63A0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mask_err, msg_req, ack = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  msi_irq_ctrl #(.FIFO_DEPTH(4), .IAR_RESET(IAR_RST)) i_msi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mask_err_o(mask_err),
    .msg_req_o(msg_req), .msg_addr_o(msg_addr), .msg_data_o(msg_data),
    .msg_ack_i(ack)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); d = rdata; req = 1'b0;
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [3:0] b, output logic e);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); e = mask_err; req = 1'b0; we = 1'b0;
  endtask

  // serve outbound writes; hold = cycles to delay each ack
  task automatic drain(input int cycles, input int hold, input logic [31:0] iar, output int n);
    int waited = 0;
    logic [31:0] a0 = '0;
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ack = 1'b0;
      if (msg_req) begin
        if (waited == 0) a0 = msg_addr;
        else chk(msg_addr == a0, "R8 hold", msg_addr, a0);
        if (waited >= hold) begin
          chk(msg_addr == {iar[31:5], 5'b0}, "R5 addr", msg_addr, {iar[31:5], 5'b0});
          chk(msg_data == {27'b0, iar[4:0]}, "R5 data", msg_data, {27'b0, iar[4:0]});
          ack = 1'b1; n++; waited = 0;
        end else waited++;
      end
    end
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    int n;
    logic [31:0] iar;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk(!msg_req && !mask_err, "R1 outputs", {30'b0, msg_req, mask_err}, 0);
    rd(20'h00000, d); chk(d == 0, "R1 request", d, 0);
    rd(20'h00004, d); chk(d == 0, "R1 mask", d, 0);
    rd(20'h00008, d); chk(d == 0, "R1 pending", d, 0);
    rd(20'h0000C, d); chk(d == 0, "R1 control", d, 0);
    rd(20'h00010, d); chk(d == IAR_RST, "R1 iar", d, IAR_RST);
    iar = IAR_RST;

    // R7 mask errors
    wr(20'h00004, VALID, 4'hF, e); chk(e == 0, "R7 valid mask", {31'b0, e}, 0);
    rd(20'h00004, d); chk(d == VALID, "R7 mask readback", d, VALID);
    wr(20'h00004, 32'h0000_0001, 4'h0, e); chk(e == 0, "R7 no lanes", {31'b0, e}, 0);
    wr(20'h00004, 32'h8000_0000, 4'h8, e); chk(e == 1, "R7 bad bit", {31'b0, e}, 1);
    wr(20'h00004, VALID, 4'hF, e);

    // R5 R4 R2 sweep over all sources
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); src[s] = 1'b1;
      drain(8, 0, iar, n);
      chk(n == int'(VALID[s]), $sformatf("R5 src%0d count", s), n, VALID[s]);
      @(negedge clk); src[s] = 1'b0;
      drain(4, 0, iar, n);
      chk(n == 0, "R5 falling edge", n, 0);
    end
    rd(20'h00000, d); chk(d == VALID, "R4 request set", d, VALID);
    wr(20'h00000, 32'h0, 4'hF, e);
    rd(20'h00000, d); chk(d == VALID, "R4 write ignored", d, VALID);

    // R3 read clears pending
    rd(20'h00008, d); chk(d == 32'hFFFF_FFFF, "R2 pending all", d, 32'hFFFF_FFFF);
    rd(20'h00008, d); chk(d == 0, "R3 read clears", d, 0);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    wr(20'h00008, 32'h0, 4'h0, e);
    rd(20'h00008, d); chk(d == 0, "R3 write clears", d, 0);

    // R5 held line: one write; R2 pending reasserts while held
    wr(20'h00010, 32'h1234_5677, 4'hF, e); iar = 32'h1234_5677;
    @(negedge clk); src[9] = 1'b1;
    drain(20, 0, iar, n); chk(n == 1, "R5 held line", n, 1);
    rd(20'h00008, d); chk(d == 32'h200, "R2 held pending", d, 32'h200);
    rd(20'h00008, d); chk(d == 32'h200, "R3 level resets", d, 32'h200);
    @(negedge clk); src[9] = 1'b0;

    // R8 simultaneous edges with slow acks
    @(negedge clk); src = 32'h0400_21A0;
    drain(60, 2, iar, n); chk(n == 5, "R8 five writes", n, 5);
    @(negedge clk); src = '0;
    drain(4, 0, iar, n);

    // R6 bus error suppresses delivery
    wr(20'h0000C, 32'hFFFF_FFFF, 4'hF, e);
    rd(20'h0000C, d); chk(d == 32'h100, "R6 control read", d, 32'h100);
    @(negedge clk); src[5] = 1'b1;
    drain(10, 0, iar, n); chk(n == 0, "R6 suppressed", n, 0);
    @(negedge clk); src[5] = 1'b0;
    wr(20'h0000C, 32'h0, 4'h2, e);
    rd(20'h0000C, d); chk(d == 0, "R6 cleared", d, 0);
    @(negedge clk); src[5] = 1'b1;
    drain(10, 0, iar, n); chk(n == 1, "R6 delivery resumes", n, 1);
    @(negedge clk); src[5] = 1'b0;

    // R9 storage and strobes
    wr(20'h0C004, 32'hAABB_CCDD, 4'b0101, e);
    rd(20'h0C004, d); chk(d == 32'h00BB_00DD, "R9 errlog lanes", d, 32'h00BB_00DD);
    wr(20'h0C010, 32'h1234_5678, 4'hF, e);
    rd(20'h0C010, d); chk(d == 32'h1234_5678, "R9 arb mask", d, 32'h1234_5678);
    wr(20'h0C008, 32'hFFFF_FFFF, 4'hF, e);
    rd(20'h0C008, d); chk(d == 0, "R9 version", d, 0);

    // R10 unmapped and idle read data
    rd(20'h00014, d); chk(d == 0, "R10 unmapped", d, 0);
    @(negedge clk); chk(rdata == 0, "R10 idle", rdata, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule